// File: doc/BRIEF.md
# Memory Self-Test Engine with Retention Sleep Steps

This block is a built-in self-test controller for a word-oriented single-port SRAM. It runs one fixed March sequence made of ordinary read and write sweeps plus two kinds of power steps. A power step either parks the memory in deep-sleep for a programmed number of cycles or brings it back to active mode. Because of those steps, the engine can catch words that lose their contents while the array sits on a weak retention supply. It can also catch writes that the periphery drops after it has been power-gated and restored.

The engine drives the memory address, write data, write enable and read enable. It also raises a sleep request and a wake request toward a power-mode controller, and that controller answers the wake request with a ready pulse. Read data arrives one cycle after each read request, and the engine compares it with the expected background.

The first mismatch is logged: its address, its element number and the bitwise XOR of the read and expected words. The engine then carries on to the end of the sequence. When the sequence ends it raises done, together with a pass flag.

Top module: `march_retention_bist`

## Requirements
- R1: After reset, done, pass, mem_we, mem_re, sleep_req and wake_req are all low, and fail_elem, fail_addr and fail_xor are zero.
- R2: Element 1 writes the all-ones word to addresses 0 up to WORDS-1 in ascending order, one write per cycle. The first write is driven in the cycle after start is sampled in idle.
- R3: In each sleep element (numbers 2 and 5), sleep_req is high for exactly D consecutive cycles, and no read, write or wake request is driven while it is high. D is the value of dwell_cycles sampled with start. A sampled value of zero selects the DWELL_DEF parameter, whose default of 125000 cycles is 1 ms at 125 MHz.
- R4: In each wake element (numbers 3 and 6), wake_req rises in the cycle that follows the last sleep cycle. It stays high until pm_ready is sampled high, and it is low in the next cycle.
- R5: Element 4 visits the addresses in ascending order. At each address it runs three operations in consecutive cycles, in this order: read expecting all ones, write all zeros, read expecting all zeros.
- R6: Element 7 reads every address in ascending order, one per cycle, expecting all zeros.
- R7: One run contains exactly 5*WORDS memory operations, 2 sleep entries and 2 wake-ups, which gives 5N+4 operations in total. The first sleep starts after WORDS operations and the second after 4*WORDS operations.
- R8: Read data is checked in the cycle after its request. The first mismatch of a run latches three fields: fail_addr, fail_elem (4 for the first sweep, 7 for the final one) and fail_xor, which is the read word XOR the expected word. Later mismatches leave these fields unchanged, and the run continues to the end.
- R9: done rises two cycles after the final read request. pass is high with done when no mismatch was seen. Both outputs hold, with the memory and power requests idle, until the next start.
- R10: A new start clears done, pass and the latched failure fields, so that a clean run after a failing one reports pass with zero fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the engine is idle |
| dwell_cycles | input | DWELL_W | Deep-sleep dwell in cycles, where 0 selects DWELL_DEF |
| pm_ready | input | 1 | Power controller reports active mode restored |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_re |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| sleep_req | output | 1 | Request to hold the array in deep-sleep |
| wake_req | output | 1 | Request to return to active mode |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with no mismatch |
| fail_addr | output | AW | Address of the first mismatch |
| fail_elem | output | 3 | Element number of the first mismatch |
| fail_xor | output | DATA_W | Read word XOR expected word at the first mismatch |

## Verification
The bench tracks timing from the cycle in which start is sampled. The first write is due one cycle later, and each operation of a sweep follows its predecessor by exactly one cycle. Each sleep element must last the sampled dwell, and wake_req must already be high in the first cycle after the sleep ends. The comparison of a read happens one cycle after the request, so done and the failure fields are due two cycles after the final read request; the bench sets that cycle as its expected value for the rise of done. All sampling happens on the falling edge, after every register on the path has settled. The injected retention flips and dropped zero-writes give a known first failing address and element, and the bench works them out in advance from the sweep order.

// File: rtl/march_pkg.sv
package march_pkg;

  // Element numbers double as the logged fail_elem code.
  typedef enum logic [2:0] {
    EL_IDLE    = 3'd0,
    EL_FILL1   = 3'd1,
    EL_SLEEP_A = 3'd2,
    EL_WAKE_A  = 3'd3,
    EL_SWEEP   = 3'd4,
    EL_SLEEP_B = 3'd5,
    EL_WAKE_B  = 3'd6,
    EL_CHECK0  = 3'd7
  } elem_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;

  function automatic elem_e next_elem(elem_e e);
    return elem_e'(e + 3'd1);
  endfunction

  function automatic logic [1:0] last_sub(elem_e e);
    return (e == EL_SWEEP) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic is_sleep(elem_e e);
    return (e == EL_SLEEP_A) || (e == EL_SLEEP_B);
  endfunction

  function automatic logic is_wake(elem_e e);
    return (e == EL_WAKE_A) || (e == EL_WAKE_B);
  endfunction

  function automatic logic is_read(elem_e e, logic [1:0] s);
    return ((e == EL_SWEEP) && (s != 2'd1)) || (e == EL_CHECK0);
  endfunction

  function automatic logic is_write(elem_e e, logic [1:0] s);
    return (e == EL_FILL1) || ((e == EL_SWEEP) && (s == 2'd1));
  endfunction

  // Background bit for the current operation: ones for the fill and the
  // first read of the sweep, zeros everywhere else.
  function automatic logic bg_bit(elem_e e, logic [1:0] s);
    return (e == EL_FILL1) || ((e == EL_SWEEP) && (s == 2'd0));
  endfunction

endpackage

// File: rtl/march_dwell_timer.sv
module march_dwell_timer #(
  parameter int CW  = 20,
  parameter int DEF = 125000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] dwell_in,
  input  logic          active,
  output logic          expire
);
  localparam logic [CW-1:0] DEF_V = CW'(DEF);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  logic [CW-1:0] len_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load) len_q <= (dwell_in == '0) ? DEF_V : dwell_in;
      if (!active) cnt_q <= '0;
      else         cnt_q <= cnt_q + ONE_V;
    end
  end

  assign expire = active && (cnt_q == len_q - ONE_V);
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int WORDS = 12,
  parameter int AW    = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          expire,
  input  logic          pm_ready,
  output phase_e        phase,
  output elem_e         elem,
  output logic [AW-1:0] addr,
  output logic [1:0]    sub
);
  localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1);
  localparam logic [AW-1:0] STEP_A = AW'(1);

  phase_e        phase_q;
  elem_e         elem_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    sub_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      elem_q  <= EL_IDLE;
      addr_q  <= '0;
      sub_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (go) begin
          phase_q <= PH_RUN;
          elem_q  <= EL_FILL1;
          addr_q  <= '0;
          sub_q   <= '0;
        end
        PH_RUN: begin
          if (is_sleep(elem_q)) begin
            if (expire) elem_q <= next_elem(elem_q);
          end else if (is_wake(elem_q)) begin
            if (pm_ready) elem_q <= next_elem(elem_q);
          end else if (sub_q != last_sub(elem_q)) begin
            sub_q <= sub_q + 2'd1;
          end else begin
            sub_q <= '0;
            if (addr_q != LAST_A) begin
              addr_q <= addr_q + STEP_A;
            end else begin
              addr_q <= '0;
              if (elem_q == EL_CHECK0) begin
                phase_q <= PH_DRAIN;
                elem_q  <= EL_IDLE;
              end else begin
                elem_q <= next_elem(elem_q);
              end
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase = phase_q;
  assign elem  = elem_q;
  assign addr  = addr_q;
  assign sub   = sub_q;
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
  parameter int DW = 16,
  parameter int AW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          chk_vld,
  input  logic [DW-1:0] chk_exp,
  input  logic [AW-1:0] chk_addr,
  input  logic [2:0]    chk_elem,
  input  logic [DW-1:0] rdata,
  input  logic          drain,
  output logic          done,
  output logic          pass,
  output logic [AW-1:0] fail_addr,
  output logic [2:0]    fail_elem,
  output logic [DW-1:0] fail_xor
);
  logic          p_vld;
  logic [DW-1:0] p_exp;
  logic [AW-1:0] p_addr;
  logic [2:0]    p_elem;
  logic          seen_q, done_q;
  logic [AW-1:0] fa_q;
  logic [2:0]    fe_q;
  logic [DW-1:0] fx_q;
  logic          miss;

  assign miss = p_vld && (rdata != p_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_exp  <= '0;
      p_addr <= '0;
      p_elem <= '0;
      seen_q <= 1'b0;
      done_q <= 1'b0;
      fa_q   <= '0;
      fe_q   <= '0;
      fx_q   <= '0;
    end else begin
      p_vld <= chk_vld;
      if (chk_vld) begin
        p_exp  <= chk_exp;
        p_addr <= chk_addr;
        p_elem <= chk_elem;
      end
      if (clear) begin
        seen_q <= 1'b0;
        done_q <= 1'b0;
        fa_q   <= '0;
        fe_q   <= '0;
        fx_q   <= '0;
      end else begin
        if (drain) done_q <= 1'b1;
        if (miss && !seen_q) begin
          seen_q <= 1'b1;
          fa_q   <= p_addr;
          fe_q   <= p_elem;
          fx_q   <= rdata ^ p_exp;
        end
      end
    end
  end

  assign done      = done_q;
  assign pass      = done_q && !seen_q;
  assign fail_addr = fa_q;
  assign fail_elem = fe_q;
  assign fail_xor  = fx_q;
endmodule

// File: rtl/march_retention_bist.sv
module march_retention_bist
  import march_pkg::*;
#(
  parameter int WORDS     = 12,
  parameter int DATA_W    = 16,
  parameter int DWELL_W   = 20,
  parameter int DWELL_DEF = 125000,
  localparam int AW       = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [DWELL_W-1:0] dwell_cycles,
  input  logic               pm_ready,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [AW-1:0]      mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               mem_we,
  output logic               mem_re,
  output logic               sleep_req,
  output logic               wake_req,
  output logic               done,
  output logic               pass,
  output logic [AW-1:0]      fail_addr,
  output logic [2:0]         fail_elem,
  output logic [DATA_W-1:0]  fail_xor
);
  phase_e        phase;
  elem_e         elem;
  logic [AW-1:0] addr;
  logic [1:0]    sub;
  logic          start_acc;
  logic          in_run;
  logic          dwell_expire;
  logic          bg;

  assign start_acc = start && (phase == PH_IDLE);
  assign in_run    = (phase == PH_RUN);
  assign bg        = bg_bit(elem, sub);

  assign mem_addr  = addr;
  assign mem_wdata = {DATA_W{bg}};
  assign mem_we    = in_run && is_write(elem, sub);
  assign mem_re    = in_run && is_read(elem, sub);
  assign sleep_req = in_run && is_sleep(elem);
  assign wake_req  = in_run && is_wake(elem);

  march_seq #(.WORDS(WORDS), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(start_acc), .expire(dwell_expire),
    .pm_ready(pm_ready), .phase(phase), .elem(elem), .addr(addr), .sub(sub)
  );

  march_dwell_timer #(.CW(DWELL_W), .DEF(DWELL_DEF)) u_dwell (
    .clk(clk), .rst_n(rst_n), .load(start_acc), .dwell_in(dwell_cycles),
    .active(sleep_req), .expire(dwell_expire)
  );

  march_cmp #(.DW(DATA_W), .AW(AW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .chk_vld(mem_re),
    .chk_exp({DATA_W{bg}}), .chk_addr(addr), .chk_elem(elem),
    .rdata(mem_rdata), .drain(phase == PH_DRAIN), .done(done), .pass(pass),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_xor(fail_xor)
  );
endmodule

// File: rtl/march_retention_bist_chk.sv
module march_retention_bist_chk #(
  parameter int WORDS  = 12,
  parameter int DATA_W = 16,
  localparam int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
)(
  input logic              clk,
  input logic              rst_n,
  input logic              start_acc,
  input logic              pm_ready,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              sleep_req,
  input logic              wake_req,
  input logic              done,
  input logic [AW-1:0]     fail_addr,
  input logic [2:0]        fail_elem,
  input logic [DATA_W-1:0] fail_xor
);
  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_we, mem_re, sleep_req, wake_req}) <= 1); // R3

  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (int'(mem_addr) < WORDS)); // R2

  AST_WAKE_AFTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_req) |-> wake_req); // R4

  AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && !pm_ready) |=> wake_req); // R4

  AST_WAKE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && pm_ready) |=> !wake_req); // R4

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_elem != 3'd0) && !start_acc) |=>
      ($stable(fail_addr) && $stable(fail_elem) && $stable(fail_xor))); // R8

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_acc) |=> done); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(mem_we || mem_re || sleep_req || wake_req)); // R9
endmodule

bind march_retention_bist march_retention_bist_chk #(.WORDS(WORDS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .pm_ready(pm_ready),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
  .sleep_req(sleep_req), .wake_req(wake_req), .done(done),
  .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_xor(fail_xor)
);

// File: tb/sim_march_retention_bist.sv
module sim_march_retention_bist;
  localparam int WORDS = 12;
  localparam int DW    = 16;
  localparam int CW    = 20;
  localparam int DEF   = 37;
  localparam int AW    = $clog2(WORDS);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] dwell_cycles = '0;
  logic          pm_ready = 1'b0;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, fail_xor;
  logic          mem_we, mem_re, sleep_req, wake_req, done, pass;
  logic [2:0]    fail_elem;

  march_retention_bist #(.WORDS(WORDS), .DATA_W(DW), .DWELL_W(CW), .DWELL_DEF(DEF)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dwell_cycles(dwell_cycles),
    .pm_ready(pm_ready), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .sleep_req(sleep_req), .wake_req(wake_req), .done(done), .pass(pass),
    .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_xor(fail_xor)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  bit prev_failed = 0;

  // fault controls for the memory model
  int          ret_a_addr = -1, ret_b_addr = -1, drop_addr = -1;
  logic [DW-1:0] ret_a_mask = '0, ret_b_mask = '0;

  logic [DW-1:0] mem [WORDS];
  logic slp_d, slp_ph;

  always @(posedge clk) begin
    if (mem_we && !((int'(mem_addr) == drop_addr) && (mem_wdata == '0)))
      mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (sleep_req && !slp_d) begin
      if (!slp_ph && ret_a_addr >= 0) mem[ret_a_addr] <= mem[ret_a_addr] ^ ret_a_mask;
      if (slp_ph && ret_b_addr >= 0)  mem[ret_b_addr] <= mem[ret_b_addr] ^ ret_b_mask;
    end
    if (!rst_n) begin
      slp_d  <= 1'b0;
      slp_ph <= 1'b0;
    end else begin
      slp_d <= sleep_req;
      if (sleep_req && !slp_d) slp_ph <= ~slp_ph;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference order of memory operations: 1=write, 0=read
  function automatic void op_ref(input int i, output bit wr, output int a, output logic [DW-1:0] d);
    int j;
    if (i < WORDS) begin
      wr = 1; a = i; d = '1;
    end else if (i < 4 * WORDS) begin
      j = i - WORDS; a = j / 3; wr = ((j % 3) == 1); d = '0;
    end else begin
      wr = 0; a = i - 4 * WORDS; d = '0;
    end
  endfunction

  function automatic string op_req(input int i);
    if (i < WORDS) return "R2";
    if (i < 4 * WORDS) return "R5";
    return "R6";
  endfunction

  task automatic run(input int dwell, input int lat, input int ra, input logic [DW-1:0] ma,
                     input int rb, input logic [DW-1:0] mb, input int dr);
    int e_elem = 0, e_addr = 0, key = 1 << 30, exp_dwell;
    logic [DW-1:0] e_xor = '0;
    bit e_fail = 0;
    int cyc, ops = 0, nsl = 0, nwk = 0, slen = 0, last_op = 0, wkw = 0;
    bit sp = 0, wp = 0;
    bit ewr; int ea; logic [DW-1:0] ed;
    string rq;

    if (ra >= 0 && ra * 3 < key) begin key = ra * 3; e_elem = 4; e_addr = ra; e_xor = ma; e_fail = 1; end
    if (dr >= 0 && dr * 3 + 2 < key) begin key = dr * 3 + 2; e_elem = 4; e_addr = dr; e_xor = '1; e_fail = 1; end
    if (!e_fail && rb >= 0) begin e_elem = 7; e_addr = rb; e_xor = mb; e_fail = 1; end
    exp_dwell = (dwell == 0) ? DEF : dwell;

    ret_a_addr = ra; ret_a_mask = ma; ret_b_addr = rb; ret_b_mask = mb; drop_addr = dr;
    dwell_cycles = CW'(dwell);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (mem_we || mem_re) begin
        op_ref(ops, ewr, ea, ed);
        rq = op_req(ops);
        check(mem_we == ewr && mem_re == !ewr && int'(mem_addr) == ea, rq,
              {mem_we, mem_re, 8'(mem_addr)}, {ewr, !ewr, 8'(ea)});
        if (ewr) check(mem_wdata == ed, rq, mem_wdata, ed);
        if (ops == 0) check(cyc == 1, "R2", cyc, 1);
        else if (ops != WORDS && ops != 4 * WORDS) check(cyc == last_op + 1, rq, cyc, last_op + 1);
        last_op = cyc;
        ops++;
      end
      if (sleep_req && !sp) begin
        check(ops == ((nsl == 0) ? WORDS : 4 * WORDS), "R7", ops, (nsl == 0) ? WORDS : 4 * WORDS);
        nsl++;
      end
      if (sleep_req) slen++;
      if (!sleep_req && sp) begin
        check(slen == exp_dwell, "R3", slen, exp_dwell);
        check(wake_req, "R4", wake_req, 1);
        slen = 0;
      end
      if (wake_req && !wp) nwk++;
      if (pm_ready) pm_ready = 1'b0;
      else if (wake_req) begin
        if (wkw >= lat) pm_ready = 1'b1;
        else wkw++;
      end else wkw = 0;
      sp = sleep_req;
      wp = wake_req;
      @(negedge clk);
      cyc++;
    end
    check(done, "R9", done, 1);
    check(cyc == last_op + 2, "R9", cyc, last_op + 2);
    check(ops + nsl + nwk == 5 * WORDS + 4 && nsl == 2 && nwk == 2, "R7", ops + nsl + nwk, 5 * WORDS + 4);
    check(pass == !e_fail, "R9", pass, !e_fail);
    rq = prev_failed ? "R10" : "R8";
    check(fail_elem == 3'(e_elem), rq, fail_elem, e_elem);
    check(int'(fail_addr) == e_addr, rq, fail_addr, e_addr);
    check(fail_xor == e_xor, rq, fail_xor, e_xor);
    repeat (3) @(negedge clk);
    check(done && (pass == !e_fail) && !mem_we && !mem_re && !sleep_req && !wake_req, "R9",
          {done, pass}, {1'b1, !e_fail});
    prev_failed = e_fail;
    ret_a_addr = -1; ret_b_addr = -1; drop_addr = -1;
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check(!done && !pass && !mem_we && !mem_re && !sleep_req && !wake_req, "R1",
          {done, pass, mem_we, mem_re, sleep_req, wake_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !pass && fail_elem == 0 && fail_addr == 0 && fail_xor == 0, "R1",
          {done, pass, fail_elem}, 0);

    run(5, 0, -1, '0, -1, '0, -1);                  // clean run
    run(0, 2, -1, '0, -1, '0, -1);                  // zero dwell picks default (R3)
    run(1, 1, 0, 16'h0001, -1, '0, -1);             // retention loss in first sleep
    run(3, 0, -1, '0, -1, '0, -1);                  // clean after failing run (R10)
    run(4, 3, -1, '0, WORDS - 1, 16'h8000, -1);     // retention loss in second sleep
    run(2, 0, 7, 16'h00F0, 2, 16'h0101, -1);        // two faults: first one kept (R8)
    run(6, 1, -1, '0, -1, '0, 5);                   // lost zero write at address 5
    run(2, 0, 4, 16'h0C00, -1, '0, 4);              // retention and lost write, same word
    for (int k = 0; k < 8; k++) begin
      int kind = $urandom % 4;
      int a = $urandom % WORDS;
      logic [DW-1:0] m = DW'(($urandom % 65535) + 1);
      run(1 + $urandom % 20, $urandom % 4,
          (kind == 1) ? a : -1, m, (kind == 2) ? a : -1, m, (kind == 3) ? a : -1);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule